// File: doc/BRIEF.md
# Waveform Timer Channel

A single timer channel that generates two digital waveforms. A counter advances on qualified tick pulses. It is compared against three programmable values, RA, RB and RC. Each compare match, an external event edge and a software trigger can set, clear or toggle output A or output B. Four counting modes decide how RC limits the count: free-running up, up with wrap at RC, up/down with a turn at all-ones, and up/down with a turn at RC. The external event and the software trigger can also restart the counter from zero.

Software drives the channel through a simple word-addressed register port. Writes take effect at the next clock edge. Reads are combinational. Event flags collect in a status word that clears when it is read. A mask chooses which flags raise the interrupt line.

Top module: `wave_timer_ch`

## Requirements
- R1: After reset the counter is 0, both outputs are low, the clock enable is off, all status flags and mask bits are 0, and irq is low.
- R2: A write to address 0 with bit 0 set turns the channel clock on, and with bit 1 set turns it off; when both bits are set, off wins. Status bit 16 shows whether the clock is on.
- R3: The counter moves only on a cycle with tick high while the clock is on and the channel is not halted. In mode 0 (mode bits [1:0]) it counts up and wraps from 0xFFFF to 0, and that tick sets status flag bit 0.
- R4: In mode 2 the counter counts up and goes to 0 on the tick where it equals RC, so after n ticks from zero it reads n mod (RC+1).
- R5: In mode 1 the counter turns downward at 0xFFFF, and in mode 3 it turns downward at RC. In both modes it turns upward again at 0.
- R6: A tick taken while the counter equals RA, RB or RC sets status flag bit 2, 3 or 4 respectively.
- R7: Each 2-bit action code means 0 none, 1 set, 2 clear, 3 toggle. Output A uses mode[9:8] on an RA match, [11:10] on an RC match, [13:12] on an external event and [15:14] on a software trigger. Output B uses [17:16] on an RB match, [19:18] on an RC match, [21:20] on an external event and [23:22] on a software trigger.
- R8: When several events with non-zero codes reach one output in the same cycle, only one applies. The order is software trigger, then external event, then RC match, then RA or RB match.
- R9: With mode bit 2 set, an RC match halts the counter at RC while the clock stays on. A trigger clears the halt.
- R10: With mode bit 3 set, an RC match holds the counter and turns the channel clock off.
- R11: A write to address 0 with bit 2 set zeroes the counter at that edge, resets the direction to up, and applies the software-trigger actions.
- R12: Mode bits [5:4] select which edges of ext_evt count as events: 0 none, 1 rising, 2 falling, 3 both. Each event takes effect two clocks after the input changes and sets status flag bit 7. With mode bit 6 set, the event also zeroes the counter in the same way as a trigger.
- R13: Address 6 reads status: flags in bits [7:0], output A in bit 17, output B in bit 18. A read clears the flags, but a flag set in the same cycle is kept. Address 5 reads the counter.
- R14: Writing address 7 sets mask bits and writing address 8 clears them. Only flag bits 0, 2, 3, 4 and 7 can be masked in. Address 9 reads the mask. irq is high while any flag is set in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on status read) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| tick | input | 1 | Count qualifier pulse |
| ext_evt | input | 1 | External event input |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter state shows up in the next counter read. It also shows as compare matches that fire on the wrong tick, so an output edge appears early, late or never. A direction or halt bit stuck in the wrong state appears within one tick as a step of the wrong sign or size. Flag or mask errors show on irq in the cycle after the event or the status read. Output priority errors show only when two events coincide, so the bench places compares and triggers on the same cycle on purpose.

// File: rtl/wave_timer_ch.sv
module wave_timer_ch #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          tick,
  input  logic          ext_evt,
  output logic          out_a,
  output logic          out_b,
  output logic          irq
);
  localparam logic [7:0] FLAG_USED = 8'h9D;

  logic [W-1:0] cnt, cnt_n, ra, rb, rc;
  logic [23:0]  mode;
  logic         clk_on, halted, down, down_n, ev_s1, ev_s2;
  logic [7:0]   flags, mask;

  wire ctl_wr = wr_en && addr == AW'(0);
  wire sw     = ctl_wr && wdata[2];
  wire clr    = rd_en && addr == AW'(6);

  wire [1:0] wsel    = mode[1:0];
  wire       stop_rc = mode[2];
  wire       dis_rc  = mode[3];
  wire [1:0] eedge   = mode[5:4];
  wire       etrg    = mode[6];

  wire ev   = (eedge[0] & ev_s1 & ~ev_s2) | (eedge[1] & ~ev_s1 & ev_s2);
  wire trig = sw | (etrg & ev);
  wire run  = clk_on & ~halted & tick;

  wire hit_a   = run && cnt == ra;
  wire hit_b   = run && cnt == rb;
  wire hit_c   = run && cnt == rc;
  wire rc_halt = hit_c & (stop_rc | dis_rc);
  wire updown  = wsel[0];
  wire [W-1:0] bound = wsel[1] ? rc : '1;
  wire ovf = run && cnt == '1 && !(updown && down);

  wire [7:0] new_flags = {ev, 2'b00, hit_c, hit_b, hit_a, 1'b0, ovf};

  always_comb begin
    cnt_n  = cnt;
    down_n = down;
    if (trig) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (run && !rc_halt) begin
      if (!updown)
        cnt_n = (wsel[1] && hit_c) ? '0 : cnt + 1'b1;
      else if (!down) begin
        if (cnt == bound) begin
          if (cnt != '0) begin
            cnt_n  = cnt - 1'b1;
            down_n = 1'b1;
          end
        end else
          cnt_n = cnt + 1'b1;
      end else if (cnt == '0) begin
        cnt_n  = W'(1);
        down_n = 1'b0;
      end else
        cnt_n = cnt - 1'b1;
    end
  end

  function automatic logic act(input logic cur, input logic [1:0] code);
    case (code)
      2'd1:    return 1'b1;
      2'd2:    return 1'b0;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] pick(input logic s, input logic [1:0] cs,
                                      input logic e, input logic [1:0] ce,
                                      input logic c, input logic [1:0] cc,
                                      input logic m, input logic [1:0] cm);
    if (s && cs != 2'd0)      return cs;
    else if (e && ce != 2'd0) return ce;
    else if (c && cc != 2'd0) return cc;
    else if (m)               return cm;
    else                      return 2'd0;
  endfunction

  wire [1:0] code_a = pick(sw, mode[15:14], ev, mode[13:12], hit_c, mode[11:10], hit_a, mode[9:8]);
  wire [1:0] code_b = pick(sw, mode[23:22], ev, mode[21:20], hit_c, mode[19:18], hit_b, mode[17:16]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; down <= 1'b0; halted <= 1'b0; clk_on <= 1'b0;
      ra <= '0; rb <= '0; rc <= '0; mode <= '0;
      flags <= '0; mask <= '0; out_a <= 1'b0; out_b <= 1'b0;
      ev_s1 <= 1'b0; ev_s2 <= 1'b0;
    end else begin
      ev_s1 <= ext_evt;
      ev_s2 <= ev_s1;
      cnt   <= cnt_n;
      down  <= down_n;
      out_a <= act(out_a, code_a);
      out_b <= act(out_b, code_b);
      flags <= (clr ? 8'h00 : flags) | new_flags;
      if (trig) halted <= 1'b0;
      else if (hit_c && stop_rc) halted <= 1'b1;
      if (ctl_wr && wdata[1]) clk_on <= 1'b0;
      else if (ctl_wr && wdata[0]) clk_on <= 1'b1;
      else if (hit_c && dis_rc) clk_on <= 1'b0;
      if (wr_en) begin
        case (addr)
          AW'(1): mode <= wdata[23:0];
          AW'(2): ra   <= wdata[W-1:0];
          AW'(3): rb   <= wdata[W-1:0];
          AW'(4): rc   <= wdata[W-1:0];
          AW'(7): mask <= mask | (wdata[7:0] & FLAG_USED);
          AW'(8): mask <= mask & ~wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      AW'(1):  rdata = {8'h00, mode};
      AW'(2):  rdata = 32'(ra);
      AW'(3):  rdata = 32'(rb);
      AW'(4):  rdata = 32'(rc);
      AW'(5):  rdata = 32'(cnt);
      AW'(6):  rdata = {13'h0, out_b, out_a, clk_on, 8'h00, flags};
      AW'(9):  rdata = {24'h0, mask};
      default: rdata = '0;
    endcase
  end

  assign irq = |(flags & mask);

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sw |=> cnt == '0); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !trig) |=> $stable(cnt)); // R3
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wsel == 2'd0 && !rc_halt && !trig) |=> cnt == W'($past(cnt) + 1'b1)); // R3
  AST_AUTO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && wsel == 2'd2 && !rc_halt && !trig) |=> cnt == '0); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && stop_rc && !trig) |=> cnt == $past(cnt)); // R9
  AST_DIS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_c && dis_rc && !ctl_wr) |=> !clk_on); // R10
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && new_flags == 8'h00) |=> flags == 8'h00); // R13
endmodule

// File: tb/sim_wave_timer_ch.sv
`timescale 1ns/1ps
module sim_wave_timer_ch;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, ext_evt = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata, st;
  logic out_a, out_b, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wave_timer_ch u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .ext_evt(ext_evt),
    .out_a(out_a), .out_b(out_b), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int wsel, input int stp, input int dis, input int eedge,
    input int etrg, input int ara, input int arc, input int aev, input int asw,
    input int brb, input int brc, input int bev, input int bsw);
    return 32'(wsel) | 32'(stp) << 2 | 32'(dis) << 3 | 32'(eedge) << 4 | 32'(etrg) << 6 |
           32'(ara) << 8 | 32'(arc) << 10 | 32'(aev) << 12 | 32'(asw) << 14 |
           32'(brb) << 16 | 32'(brc) << 18 | 32'(bev) << 20 | 32'(bsw) << 22;
  endfunction

  function automatic int exp_wrap(input int n, input int rcv);
    return n % (rcv + 1);
  endfunction

  function automatic int exp_tri(input int n, input int rcv);
    int p = n % (2 * rcv);
    return (p <= rcv) ? p : 2 * rcv - p;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(5, st); chk("R1 count", st, 0);
    rd(6, st); chk("R1 status", st, 0);
    chk("R1 outs/irq", {out_a, out_b, irq}, 0);
    rd(9, st); chk("R1 mask", st, 0);
    // R2
    wr(0, 1); rd(6, st); chk("R2 enable", st[16], 1);
    wr(0, 3); rd(6, st); chk("R2 disable wins", st[16], 0);
    wr(0, 1);
    // R3
    wr(2, 1000); wr(3, 1000); wr(4, 1000); wr(1, 0);
    ticks(10); repeat (3) @(negedge clk);
    rd(5, st); chk("R3 count ticks only", st, 10);
    wr(0, 2); ticks(5); rd(5, st); chk("R3 clock off holds", st, 10);
    wr(0, 1);
    // R6 R7 R13
    wr(2, 3); wr(3, 5); wr(1, mk(0,0,0,0,0, 3,0,0,0, 1,0,0,0));
    wr(0, 4); rd(6, st);
    ticks(4);
    chk("R7 toggle A on RA", {out_a, out_b}, 2'b10);
    rd(6, st); chk("R6 RA flag", st[7:0], 8'h04); chk("R13 A mirror", st[17], 1);
    ticks(2);
    chk("R7 set B on RB", {out_a, out_b}, 2'b11);
    rd(6, st); chk("R6 RB flag", st[7:0], 8'h08); chk("R13 B mirror", st[18], 1);
    rd(6, st); chk("R13 read clears", st[7:0], 0);
    wr(1, mk(0,0,0,0,0, 2,0,0,0, 3,0,0,0)); wr(0, 4); ticks(6);
    chk("R7 clear A toggle B", {out_a, out_b}, 2'b00);
    // R8
    wr(2, 8); wr(3, 8); wr(4, 8);
    wr(1, mk(0,0,0,0,0, 1,2,0,1, 2,1,0,0));
    wr(0, 4); chk("R11 sw set A", out_a, 1);
    ticks(9);
    chk("R8 RC over RA/RB", {out_a, out_b}, 2'b01);
    rd(6, st); chk("R6 RC flag", st[4], 1);
    wr(2, 1000); wr(3, 1000); wr(4, 1000);
    // R4 random
    wr(1, mk(2,0,0,0,0, 0,0,0,0, 0,0,0,0));
    for (int i = 0; i < 8; i++) begin
      int rcv = $urandom_range(2, 30);
      int n = $urandom_range(1, 90);
      wr(4, rcv); wr(0, 4); ticks(n);
      rd(5, st); chk("R4 wrap at RC", st, exp_wrap(n, rcv));
    end
    // R5 random
    wr(1, mk(3,0,0,0,0, 0,0,0,0, 0,0,0,0));
    for (int i = 0; i < 8; i++) begin
      int rcv = $urandom_range(2, 30);
      int n = $urandom_range(1, 100);
      wr(4, rcv); wr(0, 4); ticks(n);
      rd(5, st); chk("R5 turn at RC and 0", st, exp_tri(n, rcv));
    end
    // R3 R5 full range
    wr(4, 1000); wr(1, 0); wr(0, 4); rd(6, st);
    ticks(65535);
    rd(5, st); chk("R3 reach top", st, 32'hFFFF);
    wr(1, 1); ticks(1);
    rd(5, st); chk("R5 turn at top", st, 32'hFFFE);
    rd(6, st);
    wr(1, 0); ticks(2);
    rd(5, st); chk("R3 wrap to zero", st, 0);
    rd(6, st); chk("R3 overflow flag", st[0], 1);
    // R9
    wr(4, 6); wr(1, mk(0,1,0,0,0, 0,0,0,0, 0,0,0,0)); wr(0, 4);
    ticks(10); rd(5, st); chk("R9 halt at RC", st, 6);
    rd(6, st); chk("R9 clock stays on", st[16], 1);
    wr(0, 4); ticks(3); rd(5, st); chk("R9 trigger restarts", st, 3);
    // R10
    wr(4, 4); wr(1, mk(0,0,1,0,0, 0,0,0,0, 0,0,0,0)); wr(0, 4);
    ticks(8); rd(5, st); chk("R10 hold at RC", st, 4);
    rd(6, st); chk("R10 clock off", st[16], 0);
    wr(0, 5); ticks(2); rd(5, st); chk("R10 re-enable", st, 2);
    // R11
    wr(4, 1000); wr(1, mk(0,0,0,0,0, 0,0,0,3, 0,0,0,2));
    ticks(5);
    wr(0, 4);
    chk("R11 sw actions", {out_a, out_b}, 2'b10);
    rd(5, st); chk("R11 zeroed", st, 0);
    // R12
    wr(1, mk(0,0,0,1,1, 0,0,2,0, 0,0,1,0));
    ticks(7); rd(6, st);
    ext_evt = 1'b1; repeat (2) @(negedge clk);
    rd(5, st); chk("R12 rise trigger", st, 0);
    chk("R12 event actions", {out_a, out_b}, 2'b01);
    rd(6, st); chk("R12 event flag", st[7], 1);
    ext_evt = 1'b0; repeat (2) @(negedge clk);
    ticks(3); rd(5, st); chk("R12 fall ignored", st, 3);
    rd(6, st); chk("R12 no flag", st[7], 0);
    wr(1, mk(0,0,0,2,0, 0,0,3,0, 0,0,0,0));
    ext_evt = 1'b1; repeat (2) @(negedge clk);
    ext_evt = 1'b0; repeat (2) @(negedge clk);
    rd(5, st); chk("R12 no trigger when off", st, 3);
    chk("R12 falling toggles A", out_a, 1);
    rd(6, st); chk("R12 falling flag", st[7], 1);
    // R14
    wr(4, 5); wr(1, 0); wr(7, 32'h10); wr(0, 4); rd(6, st);
    chk("R14 irq idle", irq, 0);
    ticks(6); chk("R14 irq on RC", irq, 1);
    rd(6, st); chk("R14 irq cleared by read", irq, 0);
    wr(8, 32'h10); rd(9, st); chk("R14 mask cleared", st, 0);
    wr(0, 4); ticks(6); chk("R14 masked off", irq, 0);
    wr(7, 32'hFF); rd(9, st); chk("R14 usable bits", st, 32'h9D);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule